// File: doc/BRIEF.md
# SD Card Host Data Path Transfer Controller

This block sequences one data transfer of an SD card host between the command logic and the serial data lines. Software-facing logic hands it a byte length, a timeout value, a direction and an enable. It then walks a small state machine through waiting, moving bytes and, for writes, waiting out the card's programming busy period. Bit serialization, CRC, FIFO storage and register access live elsewhere. Those neighbours report progress through single-cycle strobes: a byte moved, a start bit seen, the send path ready, the card busy, or an error.

Three counters track the transfer. The remaining byte count loads the full length and falls by one for each byte. The remaining FIFO word count loads the length rounded up to whole 32-bit words. It falls once for every four bytes moved, and once more for a final partial word. The timeout counter counts card clock cycles, and only in the two states where the host waits on the card: the wait for read data and the write busy period. A transfer ends with a one-cycle completion pulse, or with a one-cycle timeout pulse if the timeout counter runs out.

Top module: `sd_datapath_ctrl`

## Requirements
- R1: After reset the state output is Idle (code 0), both counters read 0, and both event pulses are low.
- R2: While Idle, a high enable with a nonzero length moves to the read wait state (code 4) if the direction input is 1, or to the send wait state (code 1) if it is 0. In the same cycle the byte counter loads the length and the word counter loads the length divided by 4, rounded up.
- R3: While Idle, a high enable with a length of 0 keeps the state Idle and raises the completion pulse in the following cycle, with both counters at 0.
- R4: The read wait state moves to the receive state (code 5) when the start-bit strobe is high. The send wait state moves to the send state (code 2) when the send-ready strobe is high.
- R5: A byte strobe in the send or receive state lowers the byte counter by one. In any other state a byte strobe changes neither counter.
- R6: The word counter falls by one on every fourth byte of a transfer, and by one on the final byte when the length is not a multiple of 4. After b of L bytes it reads ceil(L/4) - floor(b/4), minus one more when b equals L and L is not a multiple of 4.
- R7: When the last byte moves in the receive state, the state returns to Idle and the completion pulse is high for exactly one cycle.
- R8: When the last byte moves in the send state, the state becomes busy (code 3). Busy returns to Idle with a one-cycle completion pulse once the card-busy input is low.
- R9: The timeout counter loads the timeout value T on entry to the read wait or busy state, and counts down only in those states. If the state is not left earlier, the T+1-th clock edge after entry returns the state to Idle and raises the timeout pulse for one cycle, with no completion pulse.
- R10: An error strobe in any state other than Idle returns the state to Idle without a completion pulse, and both counters keep their values.
- R11: The completion and timeout pulses are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_len | input | LEN_W | Transfer length in bytes |
| cfg_tmo | input | TMO_W | Timeout value in clock cycles |
| cfg_dir_rx | input | 1 | 1 = receive from card, 0 = send to card |
| xfer_en | input | 1 | Start request, sampled in Idle |
| rx_start | input | 1 | Start bit seen on the data lines |
| tx_go | input | 1 | Send path ready to transmit |
| byte_stb | input | 1 | One byte moved on the data lines |
| card_busy | input | 1 | Card holds the data line busy |
| xfer_err | input | 1 | Error reported by the line logic (CRC, overrun) |
| state_o | output | 3 | Current state code |
| byte_left_o | output | LEN_W | Remaining byte count |
| word_left_o | output | LEN_W-1 | Remaining FIFO word count |
| dataend_o | output | 1 | One-cycle transfer completion pulse |
| dtimeout_o | output | 1 | One-cycle data timeout pulse |

## Verification
The bench builds the block with a 12-bit length and an 8-bit timeout. With those widths, timeouts of 0 to a few cycles fire within a short run, and every byte of each transfer can be strobed and its word count checked. Its lengths cover each remainder modulo 4 and the zero case, so both the wrap decrement and the partial-word decrement are reached in both directions. Timeouts are reached in both the read wait state and the busy state.

// File: rtl/sd_dp_pkg.sv
package sd_dp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WAIT_S = 3'd1,
    ST_SEND   = 3'd2,
    ST_BUSY   = 3'd3,
    ST_WAIT_R = 3'd4,
    ST_RECV   = 3'd5
  } dp_state_e;

  function automatic logic is_timed(input dp_state_e s);
    return (s == ST_WAIT_R) || (s == ST_BUSY);
  endfunction

  function automatic logic is_moving(input dp_state_e s);
    return (s == ST_SEND) || (s == ST_RECV);
  endfunction
endpackage

// File: rtl/dp_tmo_timer.sv
module dp_tmo_timer #(
  parameter int TMO_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             run,
  input  logic [TMO_W-1:0] load_val,
  output logic             zero
);
  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                      cnt_q <= '0;
    else if (load)                cnt_q <= load_val;
    else if (run && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // R9
  tmr_countdown_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && run && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R9
  tmr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !run) |=> $stable(cnt_q));
endmodule

// File: rtl/dp_byte_counter.sv
module dp_byte_counter #(
  parameter int LEN_W = 25
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] load_val,
  input  logic             take,
  output logic [LEN_W-1:0] cnt,
  output logic             is_one,
  output logic             nonzero
);
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (load)  cnt_q <= load_val;
    else if (take)  cnt_q <= cnt_q - 1'b1;
  end

  assign cnt     = cnt_q;
  assign is_one  = (cnt_q == LEN_W'(1));
  assign nonzero = (cnt_q != '0);

  // R5
  byte_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && take) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R5
  byte_no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    take |-> nonzero);
endmodule

// File: rtl/dp_word_counter.sv
module dp_word_counter #(
  parameter int LEN_W = 25,
  localparam int WRD_W = LEN_W - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] len,
  input  logic             take,
  input  logic             last,
  output logic [WRD_W-1:0] cnt
);
  logic [WRD_W-1:0] cnt_q;
  logic [1:0]       sub_q;
  logic [LEN_W:0]   len_up;
  logic             word_done;

  assign len_up    = {1'b0, len} + (LEN_W+1)'(3);
  assign word_done = take && (sub_q == 2'd3 || last);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      sub_q <= '0;
    end else if (load) begin
      cnt_q <= len_up[LEN_W:2];
      sub_q <= '0;
    end else if (take) begin
      sub_q <= sub_q + 2'd1;
      if (word_done) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt = cnt_q;

  // R6
  word_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> (cnt_q <= $past(cnt_q)));

  // R6
  word_last_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && take && last) |=> (cnt_q == '0));
endmodule

// File: rtl/dp_fsm.sv
module dp_fsm
  import sd_dp_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      xfer_en,
  input  logic      dir_rx,
  input  logic      len_zero,
  input  logic      rx_start,
  input  logic      tx_go,
  input  logic      byte_stb,
  input  logic      card_busy,
  input  logic      xfer_err,
  input  logic      byte_nonzero,
  input  logic      byte_is_one,
  input  logic      tmr_zero,
  output dp_state_e state,
  output logic      load_xfer,
  output logic      byte_take,
  output logic      byte_last,
  output logic      tmr_load,
  output logic      tmr_run,
  output logic      dataend,
  output logic      dtimeout
);
  dp_state_e state_q, state_d;
  logic      end_d, tmo_d, end_q, tmo_q;

  assign byte_take = byte_stb && is_moving(state_q) && !xfer_err && byte_nonzero;
  assign byte_last = byte_take && byte_is_one;
  assign load_xfer = (state_q == ST_IDLE) && xfer_en;

  always_comb begin
    state_d = state_q;
    end_d   = 1'b0;
    tmo_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (xfer_en) begin
          if (len_zero) end_d = 1'b1;
          else          state_d = dir_rx ? ST_WAIT_R : ST_WAIT_S;
        end
      end
      ST_WAIT_R: begin
        if (xfer_err)      state_d = ST_IDLE;
        else if (tmr_zero) begin state_d = ST_IDLE; tmo_d = 1'b1; end
        else if (rx_start) state_d = ST_RECV;
      end
      ST_WAIT_S: begin
        if (xfer_err)   state_d = ST_IDLE;
        else if (tx_go) state_d = ST_SEND;
      end
      ST_SEND: begin
        if (xfer_err)       state_d = ST_IDLE;
        else if (byte_last) state_d = ST_BUSY;
      end
      ST_RECV: begin
        if (xfer_err)       state_d = ST_IDLE;
        else if (byte_last) begin state_d = ST_IDLE; end_d = 1'b1; end
      end
      ST_BUSY: begin
        if (xfer_err)        state_d = ST_IDLE;
        else if (tmr_zero)   begin state_d = ST_IDLE; tmo_d = 1'b1; end
        else if (!card_busy) begin state_d = ST_IDLE; end_d = 1'b1; end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign tmr_load = is_timed(state_d) && !is_timed(state_q);
  assign tmr_run  = is_timed(state_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      end_q   <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      end_q   <= end_d;
      tmo_q   <= tmo_d;
    end
  end

  assign state    = state_q;
  assign dataend  = end_q;
  assign dtimeout = tmo_q;

  // R11
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(end_q && tmo_q));

  // R9
  tmo_source_chk: assert property (@(posedge clk) disable iff (rst)
    (is_timed(state_q) && !xfer_err && tmr_zero) |=> (tmo_q && state_q == ST_IDLE));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !xfer_en) |=> (state_q == ST_IDLE));

  // R10
  err_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE && xfer_err) |=> (state_q == ST_IDLE && !end_q && !tmo_q));
endmodule

// File: rtl/sd_datapath_ctrl.sv
module sd_datapath_ctrl #(
  parameter int LEN_W = 25,
  parameter int TMO_W = 32,
  localparam int WRD_W = LEN_W - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [TMO_W-1:0] cfg_tmo,
  input  logic             cfg_dir_rx,
  input  logic             xfer_en,
  input  logic             rx_start,
  input  logic             tx_go,
  input  logic             byte_stb,
  input  logic             card_busy,
  input  logic             xfer_err,
  output logic [2:0]       state_o,
  output logic [LEN_W-1:0] byte_left_o,
  output logic [WRD_W-1:0] word_left_o,
  output logic             dataend_o,
  output logic             dtimeout_o
);
  import sd_dp_pkg::*;

  dp_state_e st;
  logic load_xfer, byte_take, byte_last, tmr_load, tmr_run, tmr_zero;
  logic byte_nz, byte_one;

  dp_fsm u_fsm (
    .clk(clk), .rst(rst), .xfer_en(xfer_en), .dir_rx(cfg_dir_rx),
    .len_zero(cfg_len == '0), .rx_start(rx_start), .tx_go(tx_go),
    .byte_stb(byte_stb), .card_busy(card_busy), .xfer_err(xfer_err),
    .byte_nonzero(byte_nz), .byte_is_one(byte_one), .tmr_zero(tmr_zero),
    .state(st), .load_xfer(load_xfer), .byte_take(byte_take),
    .byte_last(byte_last), .tmr_load(tmr_load), .tmr_run(tmr_run),
    .dataend(dataend_o), .dtimeout(dtimeout_o)
  );

  dp_tmo_timer #(.TMO_W(TMO_W)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .run(tmr_run),
    .load_val(cfg_tmo), .zero(tmr_zero)
  );

  dp_byte_counter #(.LEN_W(LEN_W)) u_bytes (
    .clk(clk), .rst(rst), .load(load_xfer), .load_val(cfg_len),
    .take(byte_take), .cnt(byte_left_o), .is_one(byte_one), .nonzero(byte_nz)
  );

  dp_word_counter #(.LEN_W(LEN_W)) u_words (
    .clk(clk), .rst(rst), .load(load_xfer), .len(cfg_len),
    .take(byte_take), .last(byte_last), .cnt(word_left_o)
  );

  assign state_o = st;

  // R5
  stb_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (!is_moving(st) && st != ST_IDLE) |=> $stable(byte_left_o) && $stable(word_left_o));

  // R7
  recv_end_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RECV && byte_take && byte_left_o == LEN_W'(1)) |=> (dataend_o && st == ST_IDLE));
endmodule

// File: tb/sd_datapath_ctrl_bench.sv
module sd_datapath_ctrl_bench;
  localparam int LW = 12;
  localparam int TW = 8;
  localparam int NV = 10;

  // {kind(1: timeout), dir_rx, len[11:0], tmo[7:0]}
  localparam logic [21:0] VEC [NV] = '{
    {1'b0, 1'b1, 12'd5,  8'd10},
    {1'b0, 1'b1, 12'd8,  8'd10},
    {1'b0, 1'b1, 12'd1,  8'd3},
    {1'b0, 1'b1, 12'd7,  8'd3},
    {1'b0, 1'b0, 12'd3,  8'd5},
    {1'b0, 1'b0, 12'd12, 8'd5},
    {1'b0, 1'b0, 12'd6,  8'd2},
    {1'b1, 1'b1, 12'd9,  8'd4},
    {1'b1, 1'b1, 12'd4,  8'd0},
    {1'b1, 1'b0, 12'd2,  8'd3}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic [LW-1:0] cfg_len = '0;
  logic [TW-1:0] cfg_tmo = '0;
  logic cfg_dir_rx = 1'b0, xfer_en = 1'b0, rx_start = 1'b0, tx_go = 1'b0;
  logic byte_stb = 1'b0, card_busy = 1'b1, xfer_err = 1'b0;
  logic [2:0] state_o;
  logic [LW-1:0] byte_left_o;
  logic [LW-2:0] word_left_o;
  logic dataend_o, dtimeout_o;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  sd_datapath_ctrl #(.LEN_W(LW), .TMO_W(TW)) u_sd_datapath_ctrl (.*);

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  function automatic int words_left(input int l, input int b);
    int w = (l + 3) / 4 - b / 4;
    if (b == l && (l % 4) != 0) w = w - 1;
    return w;
  endfunction

  task automatic start(input int l, input int t, input logic rx);
    @(negedge clk);
    cfg_len = LW'(l); cfg_tmo = TW'(t); cfg_dir_rx = rx; xfer_en = 1'b1;
    @(negedge clk);
    xfer_en = 1'b0;
  endtask

  task automatic expect_timeout(input int t, input int st);
    for (int i = 0; i < t; i++) begin
      @(negedge clk);
      eq("R9 still waiting", int'(state_o), st);
      eq("R9 no early timeout", int'(dtimeout_o), 0);
    end
    @(negedge clk);
    eq("R9 timeout pulse", int'(dtimeout_o), 1);
    eq("R9 idle after timeout", int'(state_o), 0);
    eq("R11 no dataend on timeout", int'(dataend_o), 0);
    @(negedge clk);
    eq("R11 timeout one cycle", int'(dtimeout_o), 0);
  endtask

  task automatic run_vec(input logic kind, input logic rx, input int l, input int t);
    start(l, t, rx);
    eq("R2 wait state", int'(state_o), rx ? 4 : 1);
    eq("R2 byte load", int'(byte_left_o), l);
    eq("R2 word load", int'(word_left_o), (l + 3) / 4);
    if (rx && kind) begin
      expect_timeout(t, 4);
      return;
    end
    if (rx) rx_start = 1'b1; else tx_go = 1'b1;
    @(negedge clk);
    rx_start = 1'b0; tx_go = 1'b0;
    eq("R4 moving state", int'(state_o), rx ? 5 : 2);
    for (int b = 1; b <= l; b++) begin
      byte_stb = 1'b1;
      @(negedge clk);
      if (b == l) byte_stb = 1'b0;
      eq("R5 byte count", int'(byte_left_o), l - b);
      eq("R6 word count", int'(word_left_o), words_left(l, b));
    end
    if (rx) begin
      eq("R7 idle after receive", int'(state_o), 0);
      eq("R7 dataend", int'(dataend_o), 1);
    end else begin
      eq("R8 busy after send", int'(state_o), 3);
      eq("R8 no dataend yet", int'(dataend_o), 0);
      if (kind) begin
        expect_timeout(t, 3);
        return;
      end
      @(negedge clk);
      eq("R8 busy held", int'(state_o), 3);
      card_busy = 1'b0;
      @(negedge clk);
      card_busy = 1'b1;
      eq("R8 idle after busy", int'(state_o), 0);
      eq("R8 dataend", int'(dataend_o), 1);
    end
    @(negedge clk);
    eq("R11 dataend one cycle", int'(dataend_o), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    eq("R1 state", int'(state_o), 0);
    eq("R1 bytes", int'(byte_left_o), 0);
    eq("R1 words", int'(word_left_o), 0);
    eq("R1 pulses", int'(dataend_o) + int'(dtimeout_o), 0);

    for (int v = 0; v < NV; v++)
      run_vec(VEC[v][21], VEC[v][20], int'(VEC[v][19:8]), int'(VEC[v][7:0]));

    // R3 zero length
    start(0, 5, 1'b1);
    eq("R3 stays idle", int'(state_o), 0);
    eq("R3 dataend", int'(dataend_o), 1);
    eq("R3 bytes zero", int'(byte_left_o), 0);
    eq("R3 words zero", int'(word_left_o), 0);
    @(negedge clk);
    eq("R3 dataend one cycle", int'(dataend_o), 0);

    // R5 strobe ignored in read wait state
    start(6, 20, 1'b1);
    byte_stb = 1'b1;
    @(negedge clk);
    byte_stb = 1'b0;
    eq("R5 ignored bytes", int'(byte_left_o), 6);
    eq("R5 ignored words", int'(word_left_o), 2);

    // R10 error mid-receive
    rx_start = 1'b1;
    @(negedge clk);
    rx_start = 1'b0;
    byte_stb = 1'b1;
    repeat (2) @(negedge clk);
    byte_stb = 1'b0;
    xfer_err = 1'b1; byte_stb = 1'b1;
    @(negedge clk);
    xfer_err = 1'b0; byte_stb = 1'b0;
    eq("R10 idle on error", int'(state_o), 0);
    eq("R10 no dataend", int'(dataend_o), 0);
    eq("R10 bytes held", int'(byte_left_o), 4);
    eq("R10 words held", int'(word_left_o), 2);

    // R10 error during busy
    start(1, 9, 1'b0);
    tx_go = 1'b1;
    @(negedge clk);
    tx_go = 1'b0; byte_stb = 1'b1;
    @(negedge clk);
    byte_stb = 1'b0;
    eq("R8 busy", int'(state_o), 3);
    xfer_err = 1'b1;
    @(negedge clk);
    xfer_err = 1'b0;
    eq("R10 idle from busy", int'(state_o), 0);
    eq("R10 no dataend from busy", int'(dataend_o), 0);

    // R1 reset mid-transfer
    start(7, 9, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    eq("R1 reset state", int'(state_o), 0);
    eq("R1 reset bytes", int'(byte_left_o), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule